// File: doc/BRIEF.md
# Machine Interrupt Selector

This block decides whether the hart should take a machine-level interrupt, and which one. It holds the interrupt-enable register and samples the external interrupt lines into a read-only pending register. Both are reached through a small CSR port. Its two outputs go to the trap entry logic: a request flag and the cause index of the chosen interrupt.

Three interrupt sources exist: software, timer and external, at bit positions 3, 7 and 11. A candidate is a source that is both pending and enabled. Candidates are allowed through only when the hart runs below machine privilege, or when the global machine interrupt enable is set. When several candidates exist, the lowest-numbered one wins.

The decision is held in a register and is recomputed only on defined events: an mstatus write, a write to the enable register, an mret, or a change in the sampled pending lines. Between those events the decision holds, even if the global enable or the privilege input moves. The request is dropped when the trap unit accepts the interrupt.

Top module: `irq_select_top`

## Requirements
- R1: After synchronous reset, irq_req is 0, irq_cause is 0, and the enable register reads 0 (csr_sel=0).
- R2: The enable register (csr_sel=0) stores only bits 3, 7 and 11 of a write. Every other bit reads 0. For example, writing 0xFFFFFFFF reads back as 0x00000888.
- R3: A write with csr_sel=1 (pending register) has no effect. The pending register reads irq_lines masked to bits 3, 7 and 11, starting one clock after the lines are applied.
- R4: An interrupt is a candidate only when its pending bit and its enable bit are both set. A pending but disabled source never raises irq_req.
- R5: Candidates are allowed through only when priv_lvl is below 2'b11, or glob_mie is 1. With priv_lvl=2'b11 and glob_mie=0, a re-evaluation yields irq_req=0.
- R6: Among allowed candidates, the lowest bit index becomes irq_cause: 3 before 7, and 7 before 11.
- R7: A re-evaluation event in one cycle updates irq_req and irq_cause at the next clock edge. The events are mstatus_wr, an enable-register write, mret_evt, and a change of the masked irq_lines. The evaluation uses the glob_mie, priv_lvl, enable and line values present in the event cycle.
- R8: When neither a re-evaluation event nor take_ack occurs in a cycle, irq_req and irq_cause keep their values, whatever glob_mie and priv_lvl do.
- R9: take_ack clears irq_req and irq_cause to 0 at the next edge. This holds even when a re-evaluation event falls in the same cycle.
- R10: Whenever irq_req is 0, irq_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_sel | input | 1 | Register select: 0 enable, 1 pending |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data of the selected register |
| irq_lines | input | 32 | Level-sensitive interrupt lines |
| glob_mie | input | 1 | Global machine interrupt enable (post-update value) |
| priv_lvl | input | 2 | Current privilege level, 2'b11 is machine |
| mstatus_wr | input | 1 | mstatus was written this cycle |
| mret_evt | input | 1 | An mret retires this cycle |
| take_ack | input | 1 | Trap unit accepts the interrupt |
| irq_req | output | 1 | Interrupt request |
| irq_cause | output | 5 | Cause index of the chosen interrupt |

## Verification
The hardest condition to reach is a stale decision. This is a request that stays high, or stays low, after glob_mie or priv_lvl has changed, because no re-evaluation event has occurred. The stimulus first establishes a request with several sources pending. It then moves the global enable and the privilege level with every event strobe held low. After that it acknowledges, and finally releases the stale state with an mret or an mstatus write. The bench also puts take_ack in the same cycle as an mstatus write, to show that the acknowledge wins.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = $clog2(XLEN);
    localparam logic [1:0] PRIV_MACH = 2'b11;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } csr_sel_e;

    typedef struct packed {
        logic               req;
        logic [CAUSE_W-1:0] cause;
    } decision_t;

    function automatic logic [CAUSE_W-1:0] lowest_set(input word_t v);
        logic [CAUSE_W-1:0] idx;
        idx = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (v[i]) idx = CAUSE_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
    import irq_sel_pkg::*;
#(
    parameter word_t IMPL_MASK = 32'h0000_0888
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  csr_wr_en,
    input  logic  csr_sel,
    input  word_t csr_wdata,
    input  word_t irq_lines,
    output word_t mie_q,
    output word_t mie_next,
    output word_t mip_q,
    output word_t mip_next,
    output logic  ie_write,
    output logic  pend_chg,
    output word_t csr_rdata
);
    csr_sel_e sel;
    assign sel      = csr_sel_e'(csr_sel);
    assign ie_write = csr_wr_en && (sel == SEL_ENABLE);
    assign mie_next = ie_write ? (csr_wdata & IMPL_MASK) : mie_q;
    assign mip_next = irq_lines & IMPL_MASK;
    assign pend_chg = (mip_next != mip_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mie_q <= '0;
            mip_q <= '0;
        end else begin
            mie_q <= mie_next;
            mip_q <= mip_next;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE:  csr_rdata = mie_q;
            SEL_PENDING: csr_rdata = mip_q;
            default:     csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_sel_pkg::*;
(
    input  word_t      pending,
    input  word_t      enabled,
    input  logic       glob_mie,
    input  logic [1:0] priv_lvl,
    output decision_t  choice
);
    word_t cand;
    logic  gate;
    assign gate = (priv_lvl != PRIV_MACH) || glob_mie;
    assign cand = gate ? (pending & enabled) : '0;

    always_comb begin
        choice.req   = |cand;
        choice.cause = (|cand) ? lowest_set(cand) : '0;
    end
endmodule

// File: rtl/irq_decision_reg.sv
module irq_decision_reg
    import irq_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      reeval,
    input  logic      take_ack,
    input  decision_t choice,
    output decision_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (take_ack) begin
            held <= '0;
        end else if (reeval) begin
            held <= choice;
        end
    end
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
    import irq_sel_pkg::*;
#(
    parameter word_t IMPL_MASK = 32'h0000_0888
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_wr_en,
    input  logic               csr_sel,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic [XLEN-1:0]    irq_lines,
    input  logic               glob_mie,
    input  logic [1:0]         priv_lvl,
    input  logic               mstatus_wr,
    input  logic               mret_evt,
    input  logic               take_ack,
    output logic               irq_req,
    output logic [CAUSE_W-1:0] irq_cause
);
    word_t     mie_q, mie_next, mip_q, mip_next;
    logic      ie_write, pend_chg, reeval;
    decision_t choice, held;

    irq_csr_bank #(.IMPL_MASK(IMPL_MASK)) bank_i (
        .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .irq_lines(irq_lines),
        .mie_q(mie_q), .mie_next(mie_next), .mip_q(mip_q), .mip_next(mip_next),
        .ie_write(ie_write), .pend_chg(pend_chg), .csr_rdata(csr_rdata)
    );

    irq_arbiter arb_i (
        .pending(mip_next), .enabled(mie_next), .glob_mie(glob_mie),
        .priv_lvl(priv_lvl), .choice(choice)
    );

    assign reeval = mstatus_wr || ie_write || mret_evt || pend_chg;

    irq_decision_reg dec_i (
        .clk(clk), .rst(rst), .reeval(reeval), .take_ack(take_ack),
        .choice(choice), .held(held)
    );

    assign irq_req   = held.req;
    assign irq_cause = held.cause;
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk
    import irq_sel_pkg::*;
#(
    parameter word_t IMPL_MASK = 32'h0000_0888
) (
    input logic               clk,
    input logic               rst,
    input logic               csr_wr_en,
    input logic               csr_sel,
    input word_t              irq_lines,
    input logic               glob_mie,
    input logic [1:0]         priv_lvl,
    input logic               mstatus_wr,
    input logic               mret_evt,
    input logic               take_ack,
    input logic               irq_req,
    input logic [CAUSE_W-1:0] irq_cause,
    input word_t              mie_q,
    input word_t              mip_q
);
    logic quiet;
    assign quiet = !mstatus_wr && !mret_evt && !take_ack && !(csr_wr_en && !csr_sel)
                   && ((irq_lines & IMPL_MASK) == mip_q);

    AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> irq_cause == '0); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        take_ack |=> (!irq_req && irq_cause == '0)); // R9
    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        quiet |=> ($stable(irq_req) && $stable(irq_cause))); // R8
    AST_CAUSE_IMPLEMENTED: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> IMPL_MASK[irq_cause]); // R6
    AST_ENABLE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mie_q & ~IMPL_MASK) == '0); // R2
    AST_PENDING_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && csr_sel) |=> $stable(mie_q)); // R3
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        (mstatus_wr && !take_ack && priv_lvl == PRIV_MACH && !glob_mie) |=> !irq_req); // R5
endmodule

bind irq_select_top irq_select_chk #(.IMPL_MASK(IMPL_MASK)) chk_i (
    .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
    .irq_lines(irq_lines), .glob_mie(glob_mie), .priv_lvl(priv_lvl),
    .mstatus_wr(mstatus_wr), .mret_evt(mret_evt), .take_ack(take_ack),
    .irq_req(irq_req), .irq_cause(irq_cause), .mie_q(mie_q), .mip_q(mip_q)
);

// File: tb/irq_select_top_tb_top.sv
module irq_select_top_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        csr_wr_en = 0, csr_sel = 0;
    logic [31:0] csr_wdata = 0, csr_rdata, irq_lines = 0;
    logic        glob_mie = 0, mstatus_wr = 0, mret_evt = 0, take_ack = 0;
    logic [1:0]  priv_lvl = 2'b11;
    logic        irq_req;
    logic [4:0]  irq_cause;

    int checks = 0, failures = 0;

    typedef struct {
        logic       req;
        logic [4:0] cause;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    irq_select_top dut_i (
        .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_lines(irq_lines),
        .glob_mie(glob_mie), .priv_lvl(priv_lvl), .mstatus_wr(mstatus_wr),
        .mret_evt(mret_evt), .take_ack(take_ack), .irq_req(irq_req),
        .irq_cause(irq_cause)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares outputs against the scoreboard, away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_val({e.tag, " req"}, {31'b0, irq_req}, {31'b0, e.req});
            check_val({e.tag, " cause"}, {27'b0, irq_cause}, {27'b0, e.cause});
        end
    end

    // driver: inputs are already set; run one edge, drop strobes, push expectation
    task automatic cycle(input logic er, input logic [4:0] ec, input string tag);
        @(posedge clk);
        #2;
        csr_wr_en = 0; mstatus_wr = 0; mret_evt = 0; take_ack = 0;
        sb_q.push_back('{er, ec, tag});
    endtask

    task automatic read_reg(input logic sel, input logic [31:0] exp, input string tag);
        csr_sel = sel;
        #1;
        check_val(tag, csr_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 0;
        cycle(0, 0, "R1 reset");
        read_reg(0, 32'h0, "R1 enable after reset");

        // enable all: only implemented bits kept, no pending -> idle
        csr_sel = 0; csr_wr_en = 1; csr_wdata = 32'hFFFF_FFFF;
        cycle(0, 0, "R10 enabled nothing pending");
        read_reg(0, 32'h0000_0888, "R2 enable mask");

        // write to pending is ignored
        csr_sel = 1; csr_wr_en = 1; csr_wdata = 32'hFFFF_FFFF;
        cycle(0, 0, "R3 pending write");
        read_reg(1, 32'h0, "R3 pending write ignored");
        read_reg(0, 32'h0000_0888, "R3 enable untouched by pending write");

        // disable all, raise timer line: pending but not enabled
        csr_sel = 0; csr_wr_en = 1; csr_wdata = 32'h0;
        cycle(0, 0, "R4 disable");
        irq_lines = 32'h0000_0081;
        cycle(0, 0, "R4 pending not enabled");
        read_reg(1, 32'h0000_0080, "R3 pending sampled and masked");

        // machine mode, MIE=0: gated
        csr_sel = 0; csr_wr_en = 1; csr_wdata = 32'h0000_0888;
        cycle(0, 0, "R5 gated in machine mode");

        // mstatus write sets MIE: request raised one edge later
        glob_mie = 1; mstatus_wr = 1;
        #1; check_val("R7 no change before edge", {31'b0, irq_req}, 32'h0);
        cycle(1, 7, "R7 mstatus write raises timer");

        irq_lines = 32'h0000_0088;
        cycle(1, 3, "R6 software before timer");
        irq_lines = 32'h0000_0880;
        cycle(1, 7, "R6 timer before external");

        // no event: moving the gate inputs changes nothing
        glob_mie = 0;
        cycle(1, 7, "R8 stale high after MIE drop");
        take_ack = 1;
        cycle(0, 0, "R9 ack clears");
        cycle(0, 0, "R8 stale low after ack");
        glob_mie = 1;
        cycle(0, 0, "R8 MIE rise without event");

        mret_evt = 1;
        cycle(1, 7, "R7 mret re-evaluates");

        take_ack = 1; mstatus_wr = 1;
        cycle(0, 0, "R9 ack wins over event");

        // below machine privilege: MIE does not matter
        priv_lvl = 2'b00; glob_mie = 0; mstatus_wr = 1;
        cycle(1, 7, "R5 lower privilege passes");

        irq_lines = 32'h0000_0800;
        cycle(1, 11, "R6 external alone");
        irq_lines = 32'h0000_0001;
        cycle(0, 0, "R10 only unimplemented line");
        read_reg(1, 32'h0, "R3 unimplemented line masked");

        priv_lvl = 2'b11; glob_mie = 0; irq_lines = 32'h0000_0008;
        cycle(0, 0, "R5 machine mode gated on line change");

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule